// File: doc/BRIEF.md
# Sixteen-Bit Capture/Compare Timer Channel

This block is one timer channel built around a 16-bit up-counter that advances on a tick strobe. Eight general registers share that counter. Each one is switched at run time by a mode bit. In compare mode it drives its own pin with a programmable action when the counter reaches its value, and it pulses a cutoff strobe for an external down-counter. In capture mode it latches the counter on a chosen edge of its pin.

Two further registers sit beside the general ones. One is a standalone compare register with its own output pin. The other is a read-only capture register that latches the counter on an edge of a trigger input arriving from elsewhere. Compare, capture, trigger and overflow events set sticky interrupt flags. Software clears a flag by writing 1 to it. A simple write port and a combinational read port give access to the registers.

Register map (address: meaning): 0 to 7 are the general registers, 8 is the standalone compare register, 9 holds the flags (write 1 to clear), 10 is the counter (read and load), and 11 is the trigger capture register (read only).

Top module: `capcmp_timer16`

## Requirements
- R1: The counter resets to 0. It rises by 1 on every clock edge where tick_i is high and holds otherwise. A write to address 10 loads wr_data_i, and that load takes precedence over a tick in the same cycle.
- R2: A tick with the counter at 16'hFFFF wraps it to 0 and sets flag bit 10.
- R3: A general register k in compare mode (gr_mode_i[k]=1) matches on an edge where tick_i is high and the counter equals its value. On that edge the register applies the action in gr_act_i[2k+1:2k] to cc_pin_o[k] (00 hold, 01 drive 0, 10 drive 1, 11 toggle) and sets flag bit k.
- R4: Without a tick there is no match, even when the counter equals the register: the pin and the flag stay unchanged.
- R5: A general register k in capture mode (gr_mode_i[k]=0) loads the counter value on an edge where cc_pin_i[k] differs from its value on the previous edge. The edge has to be enabled by gr_edge_i[2k+1:2k] (00 none, 01 rising, 10 falling, 11 both), and a capture sets flag bit k.
- R6: In capture mode, cc_pin_o[k] holds its value whatever the counter does. In compare mode, edges on cc_pin_i[k] do not change the register.
- R7: The trigger capture register (address 11) loads the counter on an edge of trig_i enabled by trig_edge_i (same encoding as R5) and sets flag bit 9. Edges that are not enabled leave it unchanged.
- R8: The standalone compare register (address 8) matches on a tick when the counter equals its value. It then applies ocr_act_i (encoding as in R3) to ocr_pin_o and sets flag bit 8.
- R9: cutoff_o[k] is high for exactly the one cycle after a compare match of general register k, and it never rises for a register in capture mode.
- R10: Flags are sticky and are cleared by writing 1s to address 9. Bits written 0 are kept. An event in the same cycle as the clear of its bit leaves the bit set.
- R11: After reset every register, flag, pin and strobe is 0.
- R12: A software write to a general register takes precedence over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Write address |
| wr_data_i | input | 16 | Write data |
| rd_addr_i | input | 4 | Read address |
| rd_data_o | output | 16 | Read data (combinational) |
| gr_mode_i | input | 8 | Per general register: 1 compare, 0 capture |
| gr_act_i | input | 16 | Per general register: 2-bit compare action |
| gr_edge_i | input | 16 | Per general register: 2-bit capture edge select |
| ocr_act_i | input | 2 | Standalone compare action |
| trig_edge_i | input | 2 | Trigger capture edge select |
| cc_pin_i | input | 8 | Capture inputs, one per general register |
| trig_i | input | 1 | Trigger input for the dedicated capture register |
| cc_pin_o | output | 8 | Compare outputs, one per general register |
| ocr_pin_o | output | 1 | Standalone compare output |
| cutoff_o | output | 8 | One-cycle cutoff strobes for external down-counters |
| irq_flags_o | output | 11 | Sticky flags: 7..0 general, 8 compare, 9 trigger, 10 overflow |

## Verification
The bench drives compare matches at 16'hFFFF and at 0 across the wrap. A design that compared against the already-incremented counter would act one tick late, and one that ignored the tick gate would fire while the counter is stopped. Capture runs through all four edge selections. An edge detector that misread the encoding would latch on edges that were switched off or miss edges that were enabled. The bench also sets up each collision between a software action and a hardware event: a counter load together with a tick, a register write together with a capture, and a flag clear together with the event that sets it. A wrong priority in any of these shows up as a stale or off-by-one value. A register in capture mode is ticked past its own value with the toggle action selected, to catch a pin or cutoff strobe that leaks out of the wrong mode.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } cmp_act_e;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;

  function automatic logic next_pin(cmp_act_e act, logic cur);
    case (act)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

  function automatic logic edge_hit(edge_sel_e sel, logic prev, logic cur);
    case (sel)
      EDGE_RISE: return ~prev & cur;
      EDGE_FALL: return prev & ~cur;
      EDGE_BOTH: return prev ^ cur;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/ccp_edge_det.sv
module ccp_edge_det
  import capcmp_pkg::*;
#(
  parameter int W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [W-1:0]   sig_i,
  input  logic [2*W-1:0] sel_i,
  output logic [W-1:0]   hit_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= sig_i;
  end

  always_comb begin
    for (int k = 0; k < W; k++) begin
      hit_o[k] = edge_hit(edge_sel_e'(sel_i[2*k +: 2]), prev_q[k], sig_i[k]);
    end
  end

endmodule

// File: rtl/ccp_counter.sv
module ccp_counter #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (tick_i) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i & ~ld_i & (&cnt_q);

  assert_count_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !ld_i) |=> (cnt_o == $past(cnt_o) + W'(1)));

  assert_load_wins_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_i |=> (cnt_o == $past(ld_val_i)));

  assert_hold_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ld_i) |=> $stable(cnt_o));

  assert_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_o == '0));

endmodule

// File: rtl/ccp_slot.sv
module ccp_slot
  import capcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] cnt_i,
  input  logic         tick_i,
  input  logic         cmp_mode_i,
  input  logic [1:0]   act_i,
  input  logic         cap_hit_i,
  input  logic         wr_i,
  input  logic [W-1:0] wr_val_i,
  output logic [W-1:0] val_o,
  output logic         pin_o,
  output logic         cutoff_o,
  output logic         event_o
);

  logic [W-1:0] val_q;
  logic         pin_q, cutoff_q;
  logic         match, cap;

  assign match = tick_i & cmp_mode_i & (cnt_i == val_q);
  assign cap   = cap_hit_i & ~cmp_mode_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q    <= '0;
      pin_q    <= 1'b0;
      cutoff_q <= 1'b0;
    end else begin
      if (wr_i)     val_q <= wr_val_i;   // software beats capture
      else if (cap) val_q <= cnt_i;
      if (match)    pin_q <= next_pin(cmp_act_e'(act_i), pin_q);
      cutoff_q <= match;
    end
  end

  assign val_o    = val_q;
  assign pin_o    = pin_q;
  assign cutoff_o = cutoff_q;
  assign event_o  = match | cap;

  assert_act_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && act_i == 2'b10) |=> pin_o);

  assert_act_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && act_i == 2'b01) |=> !pin_o);

  assert_act_toggle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match && act_i == 2'b11) |=> (pin_o != $past(pin_o)));

  assert_no_tick_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pin_o));

  assert_capture_value_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hit_i && !cmp_mode_i && !wr_i) |=> (val_o == $past(cnt_i)));

  assert_cap_mode_pin_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmp_mode_i |=> $stable(pin_o));

  assert_cutoff_cmp_only_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cutoff_o |-> $past(cmp_mode_i));

  assert_write_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (val_o == $past(wr_val_i)));

endmodule

// File: rtl/capcmp_timer16.sv
module capcmp_timer16
  import capcmp_pkg::*;
#(
  parameter  int NUM_GR = 8,
  parameter  int CNT_W  = 16,
  localparam int ADDR_W = $clog2(NUM_GR + 4),
  localparam int FLAG_W = NUM_GR + 3
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CNT_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]   rd_addr_i,
  output logic [CNT_W-1:0]    rd_data_o,
  input  logic [NUM_GR-1:0]   gr_mode_i,
  input  logic [2*NUM_GR-1:0] gr_act_i,
  input  logic [2*NUM_GR-1:0] gr_edge_i,
  input  logic [1:0]          ocr_act_i,
  input  logic [1:0]          trig_edge_i,
  input  logic [NUM_GR-1:0]   cc_pin_i,
  input  logic                trig_i,
  output logic [NUM_GR-1:0]   cc_pin_o,
  output logic                ocr_pin_o,
  output logic [NUM_GR-1:0]   cutoff_o,
  output logic [FLAG_W-1:0]   irq_flags_o
);

  localparam logic [ADDR_W-1:0] A_OCR  = ADDR_W'(NUM_GR);
  localparam logic [ADDR_W-1:0] A_FLAG = ADDR_W'(NUM_GR + 1);
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(NUM_GR + 2);
  localparam logic [ADDR_W-1:0] A_TCR  = ADDR_W'(NUM_GR + 3);

  logic [CNT_W-1:0]  cnt;
  logic              wrap;
  logic [NUM_GR:0]   hits;
  logic [CNT_W-1:0]  gr_val [NUM_GR];
  logic [NUM_GR-1:0] gr_ev;
  logic [CNT_W-1:0]  ocr_q, tcr_q;
  logic              ocr_pin_q, ocr_hit, tcr_hit;
  logic [FLAG_W-1:0] flags_q, clr_mask, ev_vec, keep_mask;

  ccp_counter #(.W(CNT_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .ld_i     (wr_en_i && wr_addr_i == A_CNT),
    .ld_val_i (wr_data_i),
    .cnt_o    (cnt),
    .wrap_o   (wrap)
  );

  // top bit is the trigger input, the rest are the general-register pins
  ccp_edge_det #(.W(NUM_GR + 1)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  ({trig_i, cc_pin_i}),
    .sel_i  ({trig_edge_i, gr_edge_i}),
    .hit_o  (hits)
  );

  for (genvar g = 0; g < NUM_GR; g++) begin : g_slot
    ccp_slot #(.W(CNT_W)) u_slot (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .tick_i     (tick_i),
      .cmp_mode_i (gr_mode_i[g]),
      .act_i      (gr_act_i[2*g +: 2]),
      .cap_hit_i  (hits[g]),
      .wr_i       (wr_en_i && wr_addr_i == ADDR_W'(g)),
      .wr_val_i   (wr_data_i),
      .val_o      (gr_val[g]),
      .pin_o      (cc_pin_o[g]),
      .cutoff_o   (cutoff_o[g]),
      .event_o    (gr_ev[g])
    );
  end

  assign ocr_hit = tick_i & (cnt == ocr_q);
  assign tcr_hit = hits[NUM_GR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ocr_q     <= '0;
      ocr_pin_q <= 1'b0;
      tcr_q     <= '0;
    end else begin
      if (wr_en_i && wr_addr_i == A_OCR) ocr_q <= wr_data_i;
      if (ocr_hit) ocr_pin_q <= next_pin(cmp_act_e'(ocr_act_i), ocr_pin_q);
      if (tcr_hit) tcr_q <= cnt;
    end
  end

  assign ocr_pin_o = ocr_pin_q;

  assign clr_mask  = (wr_en_i && wr_addr_i == A_FLAG) ? wr_data_i[FLAG_W-1:0] : '0;
  assign ev_vec    = {wrap, tcr_hit, ocr_hit, gr_ev};
  assign keep_mask = flags_q & ~clr_mask;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= keep_mask | ev_vec;
  end

  assign irq_flags_o = flags_q;

  always_comb begin
    rd_data_o = '0;
    for (int k = 0; k < NUM_GR; k++) begin
      if (rd_addr_i == ADDR_W'(k)) rd_data_o = gr_val[k];
    end
    if (rd_addr_i == A_OCR)  rd_data_o = ocr_q;
    if (rd_addr_i == A_FLAG) rd_data_o = CNT_W'(flags_q);
    if (rd_addr_i == A_CNT)  rd_data_o = cnt;
    if (rd_addr_i == A_TCR)  rd_data_o = tcr_q;
  end

  assert_trig_capture_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tcr_hit |=> (tcr_q == $past(cnt)));

  assert_trig_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tcr_hit |=> $stable(tcr_q));

  assert_ocr_high_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ocr_hit && ocr_act_i == 2'b10) |=> ocr_pin_o);

  assert_flag_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((irq_flags_o & $past(keep_mask)) == $past(keep_mask)));

  assert_flag_set_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap |=> irq_flags_o[FLAG_W-1]);

endmodule

// File: tb/capcmp_timer16_test.sv
`timescale 1ns/1ps
module capcmp_timer16_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [15:0] rd_data_o;
  logic [7:0]  gr_mode_i = 8'hFF;
  logic [15:0] gr_act_i = '0;
  logic [15:0] gr_edge_i = '0;
  logic [1:0]  ocr_act_i = '0;
  logic [1:0]  trig_edge_i = '0;
  logic [7:0]  cc_pin_i = '0;
  logic        trig_i = 1'b0;
  logic [7:0]  cc_pin_o;
  logic        ocr_pin_o;
  logic [7:0]  cutoff_o;
  logic [10:0] irq_flags_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  capcmp_timer16 uut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
    .gr_mode_i(gr_mode_i), .gr_act_i(gr_act_i), .gr_edge_i(gr_edge_i),
    .ocr_act_i(ocr_act_i), .trig_edge_i(trig_edge_i),
    .cc_pin_i(cc_pin_i), .trig_i(trig_i),
    .cc_pin_o(cc_pin_o), .ocr_pin_o(ocr_pin_o),
    .cutoff_o(cutoff_o), .irq_flags_o(irq_flags_o)
  );

  typedef struct packed {
    logic [2:0]  slot;
    logic [15:0] cmp;
    logic [1:0]  act;
    logic        exp_pin;
  } vec_t;

  // compare scenarios; expected pin follows R3 action encoding from a 0 start
  localparam vec_t VECS [8] = '{
    '{3'd0, 16'h0010, 2'b10, 1'b1},
    '{3'd1, 16'h1234, 2'b11, 1'b1},
    '{3'd0, 16'h0020, 2'b11, 1'b0},
    '{3'd2, 16'hFFFF, 2'b10, 1'b1},
    '{3'd2, 16'h0005, 2'b01, 1'b0},
    '{3'd3, 16'h8000, 2'b00, 1'b0},
    '{3'd1, 16'h0000, 2'b01, 1'b0},
    '{3'd7, 16'h00FF, 2'b11, 1'b1}
  };

  localparam logic [3:0] A_OCR = 4'd8, A_FLAG = 4'd9, A_CNT = 4'd10, A_TCR = 4'd11;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    cyc();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] d);
    rd_addr_i = a;
    #1;
    d = rd_data_o;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R11 reset state
    rd(A_CNT, d);  chk("R11 counter", d, 16'h0);
    rd(A_TCR, d);  chk("R11 trig reg", d, 16'h0);
    rd(4'd3, d);   chk("R11 gr3", d, 16'h0);
    chk("R11 pins", cc_pin_o, 8'h0);
    chk("R11 ocr pin", ocr_pin_o, 1'b0);
    chk("R11 cutoff", cutoff_o, 8'h0);
    chk("R11 flags", irq_flags_o, 11'h0);

    // R3/R9 table walk
    for (int i = 0; i < 8; i++) begin
      vec_t v;
      v = VECS[i];
      gr_act_i = '0;
      gr_act_i[2*v.slot +: 2] = v.act;
      wr(A_CNT, v.cmp - 16'd2);
      wr({1'b0, v.slot}, v.cmp);
      wr(A_FLAG, 16'hFFFF);
      tick_i = 1'b1;
      cyc(); cyc(); cyc();
      tick_i = 1'b0;
      chk($sformatf("R3 pin vec%0d", i), cc_pin_o[v.slot], v.exp_pin);
      chk($sformatf("R3 flag vec%0d", i), irq_flags_o[v.slot], 1'b1);
      chk($sformatf("R9 cutoff on vec%0d", i), cutoff_o[v.slot], 1'b1);
      cyc();
      chk($sformatf("R9 cutoff off vec%0d", i), cutoff_o[v.slot], 1'b0);
    end
    gr_act_i = '0;

    // R4 no tick, no match; then R3 toggle with tick
    wr(4'd0, 16'h0040);
    gr_act_i[1:0] = 2'b11;
    wr(A_CNT, 16'h0040);
    wr(A_FLAG, 16'hFFFF);
    cyc(); cyc(); cyc();
    chk("R4 pin idle", cc_pin_o[0], 1'b0);
    chk("R4 flag idle", irq_flags_o[0], 1'b0);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    chk("R3 toggle pin", cc_pin_o[0], 1'b1);
    chk("R3 toggle flag", irq_flags_o[0], 1'b1);
    gr_act_i = '0;

    // R1 load beats tick, hold, count
    tick_i = 1'b1;
    wr(A_CNT, 16'h0100);
    tick_i = 1'b0;
    rd(A_CNT, d); chk("R1 load wins", d, 16'h0100);
    cyc(); cyc();
    rd(A_CNT, d); chk("R1 hold", d, 16'h0100);
    tick_i = 1'b1;
    repeat (5) cyc();
    tick_i = 1'b0;
    rd(A_CNT, d); chk("R1 count", d, 16'h0105);

    // R2 wrap
    wr(A_FLAG, 16'hFFFF);
    wr(A_CNT, 16'hFFFF);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    rd(A_CNT, d); chk("R2 wrap value", d, 16'h0000);
    chk("R2 ovf flag", irq_flags_o[10], 1'b1);

    // R10 clear, then set-beats-clear
    wr(A_FLAG, 16'h0400);
    chk("R10 cleared", irq_flags_o[10], 1'b0);
    wr(A_CNT, 16'hFFFF);
    tick_i = 1'b1;
    wr(A_FLAG, 16'h0400);
    tick_i = 1'b0;
    chk("R10 set beats clear", irq_flags_o[10], 1'b1);
    rd(A_CNT, d); chk("R10 tick during flag write", d, 16'h0000);

    // R8 standalone compare
    wr(A_FLAG, 16'hFFFF);
    ocr_act_i = 2'b10;
    wr(A_OCR, 16'h0700);
    wr(A_CNT, 16'h06FE);
    tick_i = 1'b1;
    cyc();
    chk("R8 early", ocr_pin_o, 1'b0);
    cyc(); cyc();
    tick_i = 1'b0;
    chk("R8 pin", ocr_pin_o, 1'b1);
    chk("R8 flag", irq_flags_o[8], 1'b1);
    rd(A_OCR, d); chk("R8 readback", d, 16'h0700);

    // R10 partial clear keeps other bits
    wr(A_CNT, 16'hFFFF);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    wr(A_FLAG, 16'h0400);
    chk("R10 bit cleared", irq_flags_o[10], 1'b0);
    chk("R10 other kept", irq_flags_o[8], 1'b1);

    // R6/R9 capture-mode register ignores compare
    gr_mode_i = 8'hEF;
    gr_act_i[9:8] = 2'b11;
    wr(4'd4, 16'h0050);
    wr(A_CNT, 16'h0050);
    wr(A_FLAG, 16'hFFFF);
    tick_i = 1'b1; cyc(); tick_i = 1'b0;
    chk("R6 capture pin holds", cc_pin_o[4], 1'b0);
    chk("R9 no cutoff in capture", cutoff_o[4], 1'b0);
    rd(4'd4, d); chk("R6 no spurious capture", d, 16'h0050);
    gr_act_i = '0;

    // R5 edge selections
    gr_edge_i[9:8] = 2'b01;
    wr(A_CNT, 16'h0200);
    cc_pin_i[4] = 1'b1; cyc();
    rd(4'd4, d); chk("R5 rise", d, 16'h0200);
    chk("R5 flag", irq_flags_o[4], 1'b1);
    wr(A_CNT, 16'h0300);
    cc_pin_i[4] = 1'b0; cyc();
    rd(4'd4, d); chk("R5 fall ignored", d, 16'h0200);
    gr_edge_i[9:8] = 2'b11;
    wr(A_CNT, 16'h0333);
    cc_pin_i[4] = 1'b1; cyc();
    rd(4'd4, d); chk("R5 both", d, 16'h0333);
    gr_edge_i[9:8] = 2'b10;
    wr(A_CNT, 16'h0444);
    cc_pin_i[4] = 1'b0; cyc();
    rd(4'd4, d); chk("R5 fall", d, 16'h0444);
    gr_edge_i[9:8] = 2'b00;
    wr(A_CNT, 16'h0555);
    cc_pin_i[4] = 1'b1; cyc();
    rd(4'd4, d); chk("R5 off", d, 16'h0444);
    cc_pin_i[4] = 1'b0; cyc();

    // R12 write beats capture
    gr_edge_i[9:8] = 2'b01;
    wr(A_CNT, 16'h0900);
    cc_pin_i[4] = 1'b1;
    wr(4'd4, 16'h0ABC);
    rd(4'd4, d); chk("R12 write wins", d, 16'h0ABC);
    cc_pin_i[4] = 1'b0; cyc();

    // R6 compare-mode register ignores pin edges
    gr_mode_i = 8'hFF;
    gr_edge_i[11:10] = 2'b11;
    wr(4'd5, 16'h0777);
    wr(A_CNT, 16'h0123);
    cc_pin_i[5] = 1'b1; cyc();
    cc_pin_i[5] = 1'b0; cyc();
    rd(4'd5, d); chk("R6 compare ignores edges", d, 16'h0777);

    // R7 trigger capture
    wr(A_FLAG, 16'hFFFF);
    trig_edge_i = 2'b01;
    wr(A_CNT, 16'h0600);
    trig_i = 1'b1; cyc();
    rd(A_TCR, d); chk("R7 rise", d, 16'h0600);
    chk("R7 flag", irq_flags_o[9], 1'b1);
    wr(A_CNT, 16'h0610);
    trig_i = 1'b0; cyc();
    rd(A_TCR, d); chk("R7 fall ignored", d, 16'h0600);
    trig_edge_i = 2'b10;
    wr(A_CNT, 16'h0620);
    trig_i = 1'b1; cyc();
    rd(A_TCR, d); chk("R7 rise ignored", d, 16'h0600);
    trig_i = 1'b0; cyc();
    rd(A_TCR, d); chk("R7 fall", d, 16'h0620);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule